// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the test access port of a chip's boundary-scan logic. It runs the sixteen-state test controller from the scan clock and mode pins, keeps a 5-bit instruction, and uses that instruction to pick the register that sits between the serial input and the serial output. It can pick one of three: a one-bit bypass stage, a 32-bit identification register holding a fixed code, or an external boundary chain. The controller reaches the boundary chain through capture, shift and update strobes and reads it back on a serial return line. It also decodes four mode flags that the boundary cells use to pick between driving pins from the chain, clamping them, or only observing them.

The port follows standard behaviour only while the compliance-enable input is high. When that input falls, the controller returns at once to its reset state, loads the identification instruction and stops driving the serial output. All state is kept across any stop of the scan clock, in either phase. The serial output changes on the falling scan-clock edge, so a tester samples it on the next rising edge.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `comp_en` is 0 the controller is held in Test-Logic-Reset, `tdo_oe` is 0 and the current instruction is IDCODE (00001), so `bsr_sel` and all four mode flags are 0.
- R2: Five rising scan-clock edges with `tms` = 1 bring the controller to Test-Logic-Reset from any state, and that state loads IDCODE as the current instruction.
- R3: State moves follow the standard sixteen-state map on each rising edge of `tck`. Capture-DR, Shift-DR and Update-DR are each reached only along their standard paths.
- R4: Capture-IR loads 00001 into the instruction shift stage. Shifting it out gives 1,0,0,0,0 on `tdo`, least significant bit first.
- R5: With IDCODE current, Capture-DR loads 32'h0AEA201D, which shifts out least significant bit first.
- R6: BYPASS (11111) and CLAMP (01100) select the one-bit bypass stage. It captures 0 and then delays `tdi` by one shift.
- R7: Every opcode other than 00100, 00011, 00010 and 00001 selects the bypass stage.
- R8: EXTEST (00100), SAMPLE (00011) and PRELOAD (00010) set `bsr_sel`. During Capture-DR, Shift-DR and Update-DR the controller raises `bsr_capture`, `bsr_shift` and `bsr_update` respectively, and `tdo` follows `bsr_tdo`. With any other instruction these strobes stay at 0.
- R9: `mode_extest`, `mode_clamp`, `mode_sample` and `mode_preload` are each 1 only while the current instruction is 00100, 01100, 00011 or 00010 respectively. At most one flag is set at a time.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-IR and Shift-DR.
- R11: The current instruction changes only on leaving Update-IR or in Test-Logic-Reset. Shifting, pausing or exiting the instruction path leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| comp_en | input | 1 | Compliance enable, active high, asynchronous reset when low |
| bsr_tdo | input | 1 | Serial return from the boundary chain |
| tdo | output | 1 | Serial data out, meaningful while `tdo_oe` is 1 |
| tdo_oe | output | 1 | Output enable for `tdo`, 0 means high impedance |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Boundary chain shift strobe (Shift-DR) |
| bsr_update | output | 1 | Boundary chain update strobe (Update-DR) |
| mode_extest | output | 1 | Pins driven from the chain |
| mode_clamp | output | 1 | Pins held from the chain with bypass selected |
| mode_sample | output | 1 | Pins observed only |
| mode_preload | output | 1 | Chain loaded without driving pins |

## Verification
Some properties are checked on every rising edge: the return to Test-Logic-Reset after five `tms` highs, the instruction staying fixed outside Update-IR, the one-hot mode flags, the gating of the strobes by `bsr_sel`, and `tdo_oe` being tied to the two shift states. The bench's own scenarios cover the rest: the serial contents (the captured instruction pattern, the identification code, the one-bit delay through bypass), the routing of the boundary return line, and the asynchronous effect of dropping `comp_en` in the middle of a shift. The bench also confirms that `tdo` holds through the rising edge and moves only on the falling one.

// File: rtl/scan_port_pkg.sv
`timescale 1ns/1ps
package scan_port_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_BYPASS,
      DR_IDENT,
      DR_BOUNDARY
   } dr_sel_e;

   typedef struct packed {
      logic extest;
      logic clamp;
      logic sample;
      logic preload;
   } bsr_mode_t;

   function automatic tap_state_e tap_next(input tap_state_e cur, input logic tms);
      tap_state_e nxt;
      case (cur)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/scan_port_fsm.sv
`timescale 1ns/1ps
module scan_port_fsm
   import scan_port_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state_q
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state_q <= TS_RESET;
      else        state_q <= tap_next(state_q, tms);
   end

endmodule

// File: rtl/scan_port_ir.sv
`timescale 1ns/1ps
module scan_port_ir
   import scan_port_pkg::*;
#(
   parameter int unsigned      IR_W       = 5,
   parameter logic [IR_W-1:0]  OP_EXTEST  = 5'b00100,
   parameter logic [IR_W-1:0]  OP_CLAMP   = 5'b01100,
   parameter logic [IR_W-1:0]  OP_SAMPLE  = 5'b00011,
   parameter logic [IR_W-1:0]  OP_PRELOAD = 5'b00010,
   parameter logic [IR_W-1:0]  OP_IDCODE  = 5'b00001
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  tap_state_e      state_q,
   output logic [IR_W-1:0] ir_cur,
   output logic            ir_lsb,
   output dr_sel_e         dr_sel,
   output bsr_mode_t       mode
);

   localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] sh_nxt;

   for (genvar gi = 0; gi < IR_W; gi++) begin : g_stage
      if (gi == IR_W - 1) begin : g_top
         assign sh_nxt[gi] = tdi;
      end else begin : g_mid
         assign sh_nxt[gi] = ir_sh[gi+1];
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= IR_CAPTURE;
      end else if (state_q == TS_CAP_IR) begin
         ir_sh <= IR_CAPTURE;
      end else if (state_q == TS_SHF_IR) begin
         ir_sh <= sh_nxt;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                    ir_cur <= OP_IDCODE;
      else if (state_q == TS_RESET)  ir_cur <= OP_IDCODE;
      else if (state_q == TS_UPD_IR) ir_cur <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];

   always_comb begin
      dr_sel = DR_BYPASS;
      mode   = '0;
      if (ir_cur == OP_IDCODE) begin
         dr_sel = DR_IDENT;
      end else if (ir_cur == OP_EXTEST) begin
         dr_sel      = DR_BOUNDARY;
         mode.extest = 1'b1;
      end else if (ir_cur == OP_SAMPLE) begin
         dr_sel      = DR_BOUNDARY;
         mode.sample = 1'b1;
      end else if (ir_cur == OP_PRELOAD) begin
         dr_sel       = DR_BOUNDARY;
         mode.preload = 1'b1;
      end else if (ir_cur == OP_CLAMP) begin
         mode.clamp = 1'b1;
      end
   end

endmodule

// File: rtl/scan_port_dr.sv
`timescale 1ns/1ps
module scan_port_dr
   import scan_port_pkg::*;
#(
   parameter int unsigned      ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_CODE = 32'h0AEA201D
) (
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tdi,
   input  tap_state_e state_q,
   input  dr_sel_e    dr_sel,
   output logic       dr_lsb
);

   logic            byp_q;
   logic [ID_W-1:0] id_sh;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b0;
      end else if (dr_sel == DR_BYPASS) begin
         if (state_q == TS_CAP_DR)      byp_q <= 1'b0;
         else if (state_q == TS_SHF_DR) byp_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         id_sh <= ID_CODE;
      end else if (dr_sel == DR_IDENT) begin
         if (state_q == TS_CAP_DR)      id_sh <= ID_CODE;
         else if (state_q == TS_SHF_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
      end
   end

   assign dr_lsb = (dr_sel == DR_IDENT) ? id_sh[0] : byp_q;

endmodule

// File: rtl/scan_port_ctrl.sv
`timescale 1ns/1ps
module scan_port_ctrl
   import scan_port_pkg::*;
#(
   parameter int unsigned      IR_W       = 5,
   parameter int unsigned      ID_W       = 32,
   parameter logic [ID_W-1:0]  ID_CODE    = 32'h0AEA201D,
   parameter logic [IR_W-1:0]  OP_BYPASS  = 5'b11111,
   parameter logic [IR_W-1:0]  OP_EXTEST  = 5'b00100,
   parameter logic [IR_W-1:0]  OP_CLAMP   = 5'b01100,
   parameter logic [IR_W-1:0]  OP_SAMPLE  = 5'b00011,
   parameter logic [IR_W-1:0]  OP_PRELOAD = 5'b00010,
   parameter logic [IR_W-1:0]  OP_IDCODE  = 5'b00001
) (
   input  logic tck,
   input  logic tms,
   input  logic tdi,
   input  logic comp_en,
   input  logic bsr_tdo,
   output logic tdo,
   output logic tdo_oe,
   output logic bsr_sel,
   output logic bsr_capture,
   output logic bsr_shift,
   output logic bsr_update,
   output logic mode_extest,
   output logic mode_clamp,
   output logic mode_sample,
   output logic mode_preload
);

   if (IR_W < 2) begin : g_bad_irw
      $error("scan_port_ctrl: IR_W must be at least 2");
   end
   if (ID_W < 2) begin : g_bad_idw
      $error("scan_port_ctrl: ID_W must be at least 2");
   end
   if (ID_CODE[0] != 1'b1) begin : g_bad_id
      $error("scan_port_ctrl: identification code must end in 1");
   end
   if (OP_BYPASS != {IR_W{1'b1}}) begin : g_bad_byp
      $error("scan_port_ctrl: bypass opcode must be all ones");
   end
   if (OP_IDCODE == OP_BYPASS || OP_EXTEST == OP_IDCODE) begin : g_bad_map
      $error("scan_port_ctrl: opcode map overlaps");
   end

   tap_state_e      state_q;
   logic [IR_W-1:0] ir_cur;
   logic            ir_lsb;
   logic            dr_lsb;
   dr_sel_e         dr_sel;
   bsr_mode_t       mode;
   logic            tdo_q;
   logic            oe_q;
   logic            in_shift;

   scan_port_fsm u_fsm (
      .tck     (tck),
      .rst_n   (comp_en),
      .tms     (tms),
      .state_q (state_q)
   );

   scan_port_ir #(
      .IR_W       (IR_W),
      .OP_EXTEST  (OP_EXTEST),
      .OP_CLAMP   (OP_CLAMP),
      .OP_SAMPLE  (OP_SAMPLE),
      .OP_PRELOAD (OP_PRELOAD),
      .OP_IDCODE  (OP_IDCODE)
   ) u_ir (
      .tck     (tck),
      .rst_n   (comp_en),
      .tdi     (tdi),
      .state_q (state_q),
      .ir_cur  (ir_cur),
      .ir_lsb  (ir_lsb),
      .dr_sel  (dr_sel),
      .mode    (mode)
   );

   scan_port_dr #(
      .ID_W    (ID_W),
      .ID_CODE (ID_CODE)
   ) u_dr (
      .tck     (tck),
      .rst_n   (comp_en),
      .tdi     (tdi),
      .state_q (state_q),
      .dr_sel  (dr_sel),
      .dr_lsb  (dr_lsb)
   );

   assign in_shift = (state_q == TS_SHF_DR) || (state_q == TS_SHF_IR);

   always_ff @(negedge tck or negedge comp_en) begin
      if (!comp_en) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= in_shift;
         if (state_q == TS_SHF_IR)         tdo_q <= ir_lsb;
         else if (dr_sel == DR_BOUNDARY)   tdo_q <= bsr_tdo;
         else                              tdo_q <= dr_lsb;
      end
   end

   assign tdo          = tdo_q;
   assign tdo_oe       = oe_q;
   assign bsr_sel      = (dr_sel == DR_BOUNDARY);
   assign bsr_capture  = bsr_sel && (state_q == TS_CAP_DR);
   assign bsr_shift    = bsr_sel && (state_q == TS_SHF_DR);
   assign bsr_update   = bsr_sel && (state_q == TS_UPD_DR);
   assign mode_extest  = mode.extest;
   assign mode_clamp   = mode.clamp;
   assign mode_sample  = mode.sample;
   assign mode_preload = mode.preload;

endmodule

// File: rtl/scan_port_ctrl_chk.sv
`timescale 1ns/1ps
module scan_port_ctrl_chk
   import scan_port_pkg::*;
#(
   parameter int unsigned     IR_W      = 5,
   parameter logic [IR_W-1:0] OP_IDCODE = 5'b00001
) (
   input logic            tck,
   input logic            comp_en,
   input logic            tms,
   input logic            tdo_oe,
   input logic            bsr_sel,
   input logic            bsr_capture,
   input logic            bsr_shift,
   input logic            bsr_update,
   input logic            mode_extest,
   input logic            mode_clamp,
   input logic            mode_sample,
   input logic            mode_preload,
   input tap_state_e      state_q,
   input logic [IR_W-1:0] ir_cur
);

   logic [2:0] ones_q;

   always_ff @(posedge tck or negedge comp_en) begin
      if (!comp_en)          ones_q <= '0;
      else if (!tms)         ones_q <= '0;
      else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
   end

   // R2: five consecutive tms highs always end in Test-Logic-Reset
   a_r2_tms_reset: assert property (@(posedge tck) disable iff (!comp_en)
      (ones_q == 3'd5) |-> (state_q == TS_RESET));

   // R1, R2: Test-Logic-Reset installs the identification instruction
   a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!comp_en)
      (state_q == TS_RESET) |=> (ir_cur == OP_IDCODE));

   // R11: instruction only moves on Update-IR or in reset
   a_r11_ir_hold: assert property (@(posedge tck) disable iff (!comp_en)
      (state_q != TS_UPD_IR && state_q != TS_RESET) |=> $stable(ir_cur));

   // R9: at most one boundary mode flag
   a_r9_mode_onehot: assert property (@(posedge tck) disable iff (!comp_en)
      $onehot0({mode_extest, mode_clamp, mode_sample, mode_preload}));

   // R8: chain strobes are exclusive and only with the chain selected
   a_r8_strobe_onehot: assert property (@(posedge tck) disable iff (!comp_en)
      $onehot0({bsr_capture, bsr_shift, bsr_update}));

   a_r8_strobe_sel: assert property (@(posedge tck) disable iff (!comp_en)
      (bsr_capture || bsr_shift || bsr_update) |-> bsr_sel);

   // R3: capture strobe follows a Select-DR step
   a_r3_capture_path: assert property (@(posedge tck) disable iff (!comp_en)
      (state_q == TS_SEL_DR && !tms && bsr_sel) |=> bsr_capture);

   // R10: output enable only in the two shift states
   a_r10_oe_shift: assert property (@(posedge tck) disable iff (!comp_en)
      tdo_oe |-> (state_q == TS_SHF_DR || state_q == TS_SHF_IR));

endmodule

bind scan_port_ctrl scan_port_ctrl_chk #(
   .IR_W      (IR_W),
   .OP_IDCODE (OP_IDCODE)
) u_chk (
   .tck          (tck),
   .comp_en      (comp_en),
   .tms          (tms),
   .tdo_oe       (tdo_oe),
   .bsr_sel      (bsr_sel),
   .bsr_capture  (bsr_capture),
   .bsr_shift    (bsr_shift),
   .bsr_update   (bsr_update),
   .mode_extest  (mode_extest),
   .mode_clamp   (mode_clamp),
   .mode_sample  (mode_sample),
   .mode_preload (mode_preload),
   .state_q      (state_q),
   .ir_cur       (ir_cur)
);

// File: tb/scan_port_ctrl_bench.sv
`timescale 1ns/1ps
module scan_port_ctrl_bench;

   localparam logic [31:0] ID_EXP   = 32'h0AEA201D;
   localparam logic [4:0]  C_BYPASS = 5'b11111;
   localparam logic [4:0]  C_EXTEST = 5'b00100;
   localparam logic [4:0]  C_CLAMP  = 5'b01100;
   localparam logic [4:0]  C_SAMPLE = 5'b00011;
   localparam logic [4:0]  C_PRELD  = 5'b00010;
   localparam logic [4:0]  C_IDCODE = 5'b00001;

   logic tck = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic comp_en = 1'b1;
   logic bsr_tdo;
   logic tdo, tdo_oe, bsr_sel, bsr_capture, bsr_shift, bsr_update;
   logic mode_extest, mode_clamp, mode_sample, mode_preload;

   logic [7:0] bchain = 8'h00;

   int n_chk  = 0;
   int n_fail = 0;

   logic       s_tdo, s_oe, s_cap, s_shf, s_upd, s_sel;
   logic [3:0] s_mode;

   scan_port_ctrl u_scan_port_ctrl (
      .tck          (tck),
      .tms          (tms),
      .tdi          (tdi),
      .comp_en      (comp_en),
      .bsr_tdo      (bsr_tdo),
      .tdo          (tdo),
      .tdo_oe       (tdo_oe),
      .bsr_sel      (bsr_sel),
      .bsr_capture  (bsr_capture),
      .bsr_shift    (bsr_shift),
      .bsr_update   (bsr_update),
      .mode_extest  (mode_extest),
      .mode_clamp   (mode_clamp),
      .mode_sample  (mode_sample),
      .mode_preload (mode_preload)
   );

   always #10 tck = ~tck;

   // small stand-in boundary chain driven by the strobes
   always @(posedge tck) begin
      if (bsr_capture)    bchain <= 8'hA5;
      else if (bsr_shift) bchain <= {tdi, bchain[7:1]};
   end
   assign bsr_tdo = bchain[0];

   function automatic logic [3:0] exp_mode(input logic [4:0] c);
      return {c == C_EXTEST, c == C_CLAMP, c == C_SAMPLE, c == C_PRELD};
   endfunction

   function automatic int exp_sel(input logic [4:0] c);
      if (c == C_IDCODE) return 1;
      if (c == C_EXTEST || c == C_SAMPLE || c == C_PRELD) return 2;
      return 0;
   endfunction

   function automatic logic [7:0] exp_dout8(input logic [4:0] c, input logic [7:0] din);
      case (exp_sel(c))
         1:       return ID_EXP[7:0];
         2:       return 8'hA5;
         default: return {din[6:0], 1'b0};
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic tms_v, input logic tdi_v);
      @(negedge tck);
      #2;
      s_tdo  = tdo;
      s_oe   = tdo_oe;
      s_cap  = bsr_capture;
      s_shf  = bsr_shift;
      s_upd  = bsr_update;
      s_sel  = bsr_sel;
      s_mode = {mode_extest, mode_clamp, mode_sample, mode_preload};
      tms    = tms_v;
      tdi    = tdi_v;
   endtask

   task automatic load_ir(input logic [4:0] code, output logic [4:0] cap);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step(i == 4, code[i]);
         cap[i] = s_tdo;
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout,
                          output logic cap_f, output logic shf_f, output logic upd_f);
      dout = '0;
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      cap_f = s_cap;
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i]);
         dout[i] = s_tdo;
         if (i == 0) shf_f = s_shf;
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      upd_f = s_upd;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [4:0]  cap;
      logic [31:0] dout;
      logic        cf, sf, uf;
      logic [4:0]  code;
      logic [7:0]  din;
      void'($urandom(32'd1357));

      #1 comp_en = 1'b0;
      #30;
      // R1: held in reset with the output off and no boundary mode
      chk("R1 oe", tdo_oe, 0);
      chk("R1 sel", bsr_sel, 0);
      chk("R1 mode", {mode_extest, mode_clamp, mode_sample, mode_preload}, 0);
      @(negedge tck);
      #2 comp_en = 1'b1;
      tms = 1'b0;
      step(1'b0, 1'b0);
      chk("R10 oe idle", s_oe, 0);

      // R5: identification code after reset
      scan_dr(32, 32'h12345678, dout, cf, sf, uf);
      chk("R5 idcode", dout, ID_EXP);

      // R4 R6: bypass delays by one
      load_ir(C_BYPASS, cap);
      chk("R4 capture pattern", cap, 5'b00001);
      scan_dr(8, 32'h000000C9, dout, cf, sf, uf);
      chk("R6 bypass", dout[7:0], 8'h92);

      // R6 R9: clamp routes to bypass and raises its flag
      load_ir(C_CLAMP, cap);
      step(1'b0, 1'b0);
      chk("R9 clamp flag", s_mode, 4'b0100);
      chk("R6 clamp sel", s_sel, 0);
      scan_dr(8, 32'h00000037, dout, cf, sf, uf);
      chk("R6 clamp data", dout[7:0], 8'h6E);

      // R8: boundary chain through the strobes
      load_ir(C_SAMPLE, cap);
      scan_dr(8, 32'h0000003C, dout, cf, sf, uf);
      chk("R8 bsr capture data", dout[7:0], 8'hA5);
      chk("R8 strobes", {cf, sf, uf}, 3'b111);
      chk("R8 chain contents", bchain, 8'h3C);

      // R10: tdo only moves on the falling edge
      load_ir(C_BYPASS, cap);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      chk("R10 first bit", s_tdo, 0);
      chk("R10 oe shift", s_oe, 1);
      @(posedge tck);
      #2 chk("R10 hold after rise", tdo, 0);
      step(1'b1, 1'b0);
      chk("R10 after fall", s_tdo, 1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);

      // R11: shifting a new code does not change the instruction before Update-IR
      load_ir(C_EXTEST, cap);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(i == 4, C_BYPASS[i]);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R11 pause keeps extest", s_mode, 4'b1000);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R11 update applies", {s_sel, s_mode}, 5'b00000);

      // R2: five tms highs from Shift-DR
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      scan_dr(32, 32'hFFFF0000, dout, cf, sf, uf);
      chk("R2 idcode after tms reset", dout, ID_EXP);

      // R1: compliance drop in the middle of a shift
      load_ir(C_EXTEST, cap);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R1 oe before drop", s_oe, 1);
      #3 comp_en = 1'b0;
      #1;
      chk("R1 oe after drop", tdo_oe, 0);
      chk("R1 extest cleared", {bsr_sel, mode_extest}, 2'b00);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R1 oe held off", s_oe, 0);
      comp_en = 1'b1;
      step(1'b0, 1'b0);
      scan_dr(32, 32'h0, dout, cf, sf, uf);
      chk("R1 idcode after drop", dout, ID_EXP);

      // R3 R7 R8 R9: random opcodes mixed with the named ones
      for (int k = 0; k < 40; k++) begin
         case ($urandom_range(0, 7))
            0: code = C_EXTEST;
            1: code = C_SAMPLE;
            2: code = C_PRELD;
            3: code = C_IDCODE;
            4: code = C_CLAMP;
            default: code = 5'($urandom_range(0, 31));
         endcase
         din = 8'($urandom);
         load_ir(code, cap);
         chk("R4 capture pattern", cap, 5'b00001);
         step(1'b0, 1'b0);
         chk("R9 mode flags", s_mode, exp_mode(code));
         chk("R8 sel", s_sel, exp_sel(code) == 2);
         scan_dr(8, {24'h0, din}, dout, cf, sf, uf);
         chk("R7 dr data", dout[7:0], exp_dout8(code, din));
         chk("R3 strobe path", {cf, sf, uf}, {3{exp_sel(code) == 2}});
      end

      finish_run();
   end

endmodule